// File: doc/BRIEF.md
# Clock Output Enable and Mode Control

This block is the control logic of a four-output differential clock fanout buffer. It decides, for each output pair, whether the pair toggles or is parked low. It also decides which PLL operating mode and which input frequency range the analog core should use. A pair runs only when all of the following hold: the buffer is powered up, the PLL is locked (or bypassed), the pair's software enable bit is set, and its active-low enable pin is asserted. Gate changes are retimed onto the falling edge of the output clock. As a result, an AND of the clock with the gate never produces a shortened pulse.

The power-good / power-down pin has two roles. Its first rising edge after reset captures the PLL-mode strap, which has already been decoded from its three voltage levels. That first edge also brings the buffer up. After that, a low level parks every output and a high level restarts them, and the strap is not sampled again. Software can override the strapped PLL mode and the frequency range, but only while the matching override-enable bit is set. The strapped mode is always available on a readback field.

All asynchronous pins are synchronized into the output clock domain: power-good, lock and the enable pins. The register fields are taken to be already in that domain. The block has no data stream, so all of its pins are plain level signals without handshakes.

Top module: `fanout_oe_ctrl`

## Requirements
- R1: `out_gate[i]` is 1 only when all four conditions hold: the buffer is running, `cfg_oe[i]` is 1, `oe_n[i]` is 0, and the lock condition of R9 is met. Otherwise it is 0.
- R2: When `cfg_oe[i]` is 0, `out_gate[i]` stays 0 whatever level `oe_n[i]` has.
- R3: The PLL-mode strap is captured only on the first rising edge of `pwrgd_pd_n` after reset. Later rising edges leave `mode_rb` unchanged.
- R4: After `pwrgd_pd_n` goes low, all gates are 0 within three clock cycles. When it returns high, the outputs resume under R1.
- R5: The strap input codes are 00 = low level, 01 = mid level, 10 = high level, and 11 is treated as mid. These map to the `mode_rb` codes 00 (low bandwidth), 01 (bypass) and 11 (high bandwidth). Before the first capture, `mode_rb` is 00.
- R6: When `cfg_mode_sw_en` is 0, `pll_mode` equals `mode_rb`. When it is 1, `cfg_mode` sets the mode: 00 gives low bandwidth, 01 gives bypass, and 10 or 11 give high bandwidth (code 11).
- R7: When `cfg_freq_sw_en` is 0, `freq_sel` is 00 (100 MHz range). When it is 1, `freq_sel` follows `cfg_freq`, where 01 = 50 MHz and 10 = 125 MHz.
- R8: The reserved frequency code 11, when software selection is enabled, produces `freq_sel` 00 and sets `freq_rsvd`. In every other case `freq_rsvd` is 0.
- R9: All gates stay 0 while the synchronized lock is low, unless the effective `pll_mode` is bypass (01). In bypass the lock requirement is ignored.
- R10: A change on `oe_n[i]` or `pll_lock` sampled at rising edge k appears on `out_gate` at the falling edge after rising edge k+1. Gates only ever change on falling clock edges.
- R11: During and right after reset, all gates are 0, `freq_sel` and `freq_rsvd` are 0, and `mode_rb` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock; gates change on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd_pd_n | input | 1 | Power-good on first rise, power-down while low (asynchronous) |
| oe_n | input | N_OUT | Active-low per-output enable pins (asynchronous) |
| pll_lock | input | 1 | PLL lock flag (asynchronous) |
| strap_mode_tri | input | 2 | Decoded tri-level PLL-mode strap |
| cfg_oe | input | N_OUT | Software output enable bits, 1 = allowed |
| cfg_mode_sw_en | input | 1 | Lets software select the PLL mode |
| cfg_mode | input | 2 | Software PLL mode code |
| cfg_freq_sw_en | input | 1 | Lets software select the frequency range |
| cfg_freq | input | 2 | Software frequency range code |
| out_gate | output | N_OUT | Per-output clock gate enables |
| pll_mode | output | 2 | Effective PLL mode code |
| freq_sel | output | 2 | Effective frequency range code |
| freq_rsvd | output | 1 | Reserved frequency code requested |
| mode_rb | output | 2 | Captured strap mode for readback |

## Verification
The bench drives power-down cycles with a different strap level on the second rise. A design that resampled on every rise would change `mode_rb` at that point. It also runs the PLL in bypass with the lock flag low: a design that ignored the bypass exemption would keep every output dark, and one that dropped the lock condition entirely would open the gates too early after power-up. A software enable bit is cleared while its pin is toggled, which catches a plain OR of pin and register. The pin-to-gate latency is counted edge by edge, so a missing or extra synchronizer stage, or gating on the rising edge, shows up as a one-cycle mismatch.

// File: rtl/fanout_ctrl_pkg.sv
package fanout_ctrl_pkg;

  typedef enum logic [1:0] {
    MODE_LOBW   = 2'b00,
    MODE_BYPASS = 2'b01,
    MODE_HIBW   = 2'b11
  } pll_mode_e;

  typedef enum logic [1:0] {
    PWR_WAIT = 2'b00,
    PWR_RUN  = 2'b01,
    PWR_DOWN = 2'b10
  } pwr_state_e;

  localparam logic [1:0] TRI_LOW  = 2'b00;
  localparam logic [1:0] TRI_MID  = 2'b01;
  localparam logic [1:0] TRI_HIGH = 2'b10;

  localparam logic [1:0] FREQ_100  = 2'b00;
  localparam logic [1:0] FREQ_RSVD = 2'b11;

  // strap level -> mode; the unused code 11 falls back to bypass (mid)
  function automatic pll_mode_e strap_to_mode(input logic [1:0] lvl);
    case (lvl)
      TRI_LOW:  return MODE_LOBW;
      TRI_HIGH: return MODE_HIBW;
      default:  return MODE_BYPASS;
    endcase
  endfunction

  // software code -> mode; any code with bit 1 set is high bandwidth
  function automatic pll_mode_e code_to_mode(input logic [1:0] code);
    case (code)
      2'b00:   return MODE_LOBW;
      2'b01:   return MODE_BYPASS;
      default: return MODE_HIBW;
    endcase
  endfunction

endpackage

// File: rtl/fanout_sync.sv
module fanout_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/fanout_pwr_seq.sv
module fanout_pwr_seq
  import fanout_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pg_s,
  input  logic [1:0] strap_tri,
  output logic      running,
  output pll_mode_e strap_mode
);

  pwr_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= PWR_WAIT;
      strap_mode <= MODE_LOBW;
    end else begin
      case (st)
        PWR_WAIT: if (pg_s) begin
          st         <= PWR_RUN;
          strap_mode <= strap_to_mode(strap_tri);  // only capture point
        end
        PWR_RUN:  if (!pg_s) st <= PWR_DOWN;
        PWR_DOWN: if (pg_s)  st <= PWR_RUN;
        default:  st <= PWR_WAIT;
      endcase
    end
  end

  assign running = (st == PWR_RUN);

endmodule

// File: rtl/fanout_mode_sel.sv
module fanout_mode_sel
  import fanout_ctrl_pkg::*;
(
  input  pll_mode_e  strap_mode,
  input  logic       cfg_mode_sw_en,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_freq_sw_en,
  input  logic [1:0] cfg_freq,
  output pll_mode_e  eff_mode,
  output logic       bypass,
  output logic [1:0] freq_sel,
  output logic       freq_rsvd
);

  always_comb begin
    eff_mode = cfg_mode_sw_en ? code_to_mode(cfg_mode) : strap_mode;
  end

  assign bypass = (eff_mode == MODE_BYPASS);

  always_comb begin
    freq_sel  = FREQ_100;
    freq_rsvd = 1'b0;
    if (cfg_freq_sw_en) begin
      if (cfg_freq == FREQ_RSVD) begin
        freq_rsvd = 1'b1;
      end else begin
        freq_sel = cfg_freq;
      end
    end
  end

endmodule

// File: rtl/fanout_gate.sv
module fanout_gate #(
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             lock_ok,
  input  logic [N_OUT-1:0] cfg_oe,
  input  logic [N_OUT-1:0] oe_n_s,
  output logic [N_OUT-1:0] gate
);

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    logic want;
    logic gq;

    assign want = running & lock_ok & cfg_oe[i] & ~oe_n_s[i];

    // falling-edge retiming: the gate moves only while the clock is low
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gq <= 1'b0;
      else        gq <= want;
    end

    assign gate[i] = gq;
  end

endmodule

// File: rtl/fanout_oe_ctrl.sv
module fanout_oe_ctrl
  import fanout_ctrl_pkg::*;
#(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrgd_pd_n,
  input  logic [N_OUT-1:0] oe_n,
  input  logic             pll_lock,
  input  logic [1:0]       strap_mode_tri,
  input  logic [N_OUT-1:0] cfg_oe,
  input  logic             cfg_mode_sw_en,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_freq_sw_en,
  input  logic [1:0]       cfg_freq,
  output logic [N_OUT-1:0] out_gate,
  output logic [1:0]       pll_mode,
  output logic [1:0]       freq_sel,
  output logic             freq_rsvd,
  output logic [1:0]       mode_rb
);

  localparam int SYNC_W = N_OUT + 2;
  localparam logic [SYNC_W-1:0] SYNC_RST = {2'b00, {N_OUT{1'b1}}};

  logic [SYNC_W-1:0] async_in, sync_out;
  logic              pg_s, lock_s, running, bypass, lock_ok;
  logic [N_OUT-1:0]  oe_n_s;
  pll_mode_e         strap_mode, eff_mode;

  assign async_in = {pwrgd_pd_n, pll_lock, oe_n};

  fanout_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(async_in), .q(sync_out)
  );

  assign pg_s   = sync_out[SYNC_W-1];
  assign lock_s = sync_out[SYNC_W-2];
  assign oe_n_s = sync_out[N_OUT-1:0];

  fanout_pwr_seq u_pwr (
    .clk(clk), .rst_n(rst_n), .pg_s(pg_s), .strap_tri(strap_mode_tri),
    .running(running), .strap_mode(strap_mode)
  );

  fanout_mode_sel u_mode (
    .strap_mode(strap_mode), .cfg_mode_sw_en(cfg_mode_sw_en), .cfg_mode(cfg_mode),
    .cfg_freq_sw_en(cfg_freq_sw_en), .cfg_freq(cfg_freq),
    .eff_mode(eff_mode), .bypass(bypass), .freq_sel(freq_sel), .freq_rsvd(freq_rsvd)
  );

  assign lock_ok = bypass | lock_s;

  fanout_gate #(.N_OUT(N_OUT)) u_gate (
    .clk(clk), .rst_n(rst_n), .running(running), .lock_ok(lock_ok),
    .cfg_oe(cfg_oe), .oe_n_s(oe_n_s), .gate(out_gate)
  );

  assign pll_mode = eff_mode;
  assign mode_rb  = strap_mode;

endmodule

// File: rtl/fanout_oe_ctrl_chk.sv
module fanout_oe_ctrl_chk #(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwrgd_pd_n,
  input logic [N_OUT-1:0] oe_n,
  input logic             pll_lock,
  input logic [N_OUT-1:0] cfg_oe,
  input logic             cfg_mode_sw_en,
  input logic             cfg_freq_sw_en,
  input logic [N_OUT-1:0] out_gate,
  input logic [1:0]       pll_mode,
  input logic [1:0]       freq_sel,
  input logic             freq_rsvd,
  input logic [1:0]       mode_rb,
  input logic             running
);

  AST_REG_OE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_gate & ~cfg_oe) == '0)); // R2

  AST_PIN_OFF_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_gate & $past(oe_n, SYNC_STAGES)) == '0)); // R1

  AST_PD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwrgd_pd_n, SYNC_STAGES + 1) |-> (out_gate == '0)); // R4

  AST_LOCK_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pll_lock, SYNC_STAGES) && pll_mode != 2'b01) |-> (out_gate == '0)); // R9

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(running) |-> $stable(mode_rb)); // R3

  AST_MODE_FROM_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode_sw_en |-> (pll_mode == mode_rb)); // R6

  AST_FREQ_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_freq_sw_en |-> (freq_sel == 2'b00 && !freq_rsvd)); // R7

  AST_RSVD_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    freq_rsvd |-> (freq_sel == 2'b00)); // R8

endmodule

bind fanout_oe_ctrl fanout_oe_ctrl_chk #(.N_OUT(N_OUT), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwrgd_pd_n(pwrgd_pd_n), .oe_n(oe_n), .pll_lock(pll_lock),
  .cfg_oe(cfg_oe), .cfg_mode_sw_en(cfg_mode_sw_en), .cfg_freq_sw_en(cfg_freq_sw_en),
  .out_gate(out_gate), .pll_mode(pll_mode), .freq_sel(freq_sel), .freq_rsvd(freq_rsvd),
  .mode_rb(mode_rb), .running(running)
);

// File: tb/fanout_oe_ctrl_test.sv
module fanout_oe_ctrl_test;
  localparam int N = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         pwrgd = 1'b0;
  logic [N-1:0] oe_n = '1;
  logic         lock = 1'b0;
  logic [1:0]   strap = 2'b10;
  logic [N-1:0] cfg_oe = '1;
  logic         msw = 1'b0, fsw = 1'b0;
  logic [1:0]   cmode = 2'b00, cfreq = 2'b00;
  logic [N-1:0] gate;
  logic [1:0]   pll_mode, freq_sel, mode_rb;
  logic         freq_rsvd;

  fanout_oe_ctrl #(.N_OUT(N)) uut (
    .clk(clk), .rst_n(rst_n), .pwrgd_pd_n(pwrgd), .oe_n(oe_n), .pll_lock(lock),
    .strap_mode_tri(strap), .cfg_oe(cfg_oe), .cfg_mode_sw_en(msw), .cfg_mode(cmode),
    .cfg_freq_sw_en(fsw), .cfg_freq(cfreq), .out_gate(gate), .pll_mode(pll_mode),
    .freq_sel(freq_sel), .freq_rsvd(freq_rsvd), .mode_rb(mode_rb)
  );

  int  checks = 0, errors = 0;
  bit  model_on = 0, done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit           pg_h[$];
  bit           lk_h[$];
  logic [N-1:0] oe_h[$];
  int           m_state;   // 0 waiting, 1 running, 2 powered down
  logic [1:0]   m_strap;

  function automatic logic [1:0] lvl_code(input logic [1:0] l);
    if (l == 2'b00) return 2'b00;
    if (l == 2'b10) return 2'b11;
    return 2'b01;
  endfunction

  function automatic logic [1:0] sw_code(input logic [1:0] c);
    if (c == 2'b00) return 2'b00;
    if (c == 2'b01) return 2'b01;
    return 2'b11;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pg_h = '{1'b0, 1'b0, 1'b0};
      lk_h = '{1'b0, 1'b0, 1'b0};
      oe_h = '{'1, '1, '1};
      m_state = 0;
      m_strap = 2'b00;
    end else begin
      pg_h.push_front(pwrgd);  void'(pg_h.pop_back());
      lk_h.push_front(lock);   void'(lk_h.pop_back());
      oe_h.push_front(oe_n);   void'(oe_h.pop_back());
      if (m_state == 0 && pg_h[2]) begin
        m_state = 1;
        m_strap = lvl_code(strap);
      end else if (m_state == 1 && !pg_h[2]) m_state = 2;
      else if (m_state == 2 && pg_h[2]) m_state = 1;
    end
    #3;
    if (rst_n && model_on) begin
      logic [1:0]   e_mode, e_freq;
      logic [N-1:0] e_gate;
      e_mode = msw ? sw_code(cmode) : m_strap;
      e_freq = (fsw && cfreq != 2'b11) ? cfreq : 2'b00;
      e_gate = (m_state == 1 && (lk_h[1] || e_mode == 2'b01)) ? (cfg_oe & ~oe_h[1]) : '0;
      chk("R1 gate model", 32'(gate), 32'(e_gate));
      chk("R6 mode model", 32'(pll_mode), 32'(e_mode));
      chk("R5 readback model", 32'(mode_rb), 32'(m_strap));
      chk("R7 freq model", 32'(freq_sel), 32'(e_freq));
      chk("R8 rsvd model", 32'(freq_rsvd), 32'(fsw && cfreq == 2'b11));
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic power_up(input logic [1:0] s);
    rst_n = 1'b0; pwrgd = 1'b0;
    cyc(2);
    strap = s; rst_n = 1'b1;
    cyc(2);
    pwrgd = 1'b1;
    cyc(5);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1; model_on = 1;
    cyc(1);
    // R11 reset state
    chk("R11 gate", 32'(gate), 0);
    chk("R11 mode_rb", 32'(mode_rb), 0);
    chk("R11 freq", 32'({freq_rsvd, freq_sel}), 0);

    oe_n = '0; pwrgd = 1'b1;
    cyc(6);
    chk("R9 no lock", 32'(gate), 0);
    chk("R5 high strap", 32'(mode_rb), 32'h3);

    lock = 1'b1;
    cyc(2);
    chk("R10 not yet", 32'(gate), 0);
    cyc(1);
    chk("R10 lock to gate", 32'(gate), 32'hF);

    oe_n[2] = 1'b1;
    cyc(2);
    chk("R10 pin stop pending", 32'(gate[2]), 1);
    cyc(1);
    chk("R10 pin stop", 32'(gate), 32'hB);

    cfg_oe = 4'b1001; oe_n = '0;
    cyc(3);
    chk("R2 reg off", 32'(gate), 32'h9);
    oe_n = 4'b0010;
    cyc(3);
    chk("R2 pin ignored", 32'(gate), 32'h9);
    oe_n = 4'b1000;
    cyc(3);
    chk("R1 pin off", 32'(gate), 32'h1);
    cfg_oe = '1; oe_n = '0;

    pwrgd = 1'b0;
    cyc(4);
    chk("R4 power down", 32'(gate), 0);
    strap = 2'b00; pwrgd = 1'b1;
    cyc(5);
    chk("R3 no resample", 32'(mode_rb), 32'h3);
    chk("R4 resumed", 32'(gate), 32'hF);

    msw = 1'b1; cmode = 2'b01; lock = 1'b0;
    cyc(4);
    chk("R6 sw bypass", 32'(pll_mode), 32'h1);
    chk("R9 bypass ignores lock", 32'(gate), 32'hF);
    cmode = 2'b10;
    cyc(1);
    chk("R6 code 10 high", 32'(pll_mode), 32'h3);
    chk("R9 lock needed again", 32'(gate), 0);
    msw = 1'b0; lock = 1'b1;

    cfreq = 2'b10;
    cyc(1);
    chk("R7 sw disabled", 32'(freq_sel), 0);
    fsw = 1'b1;
    cyc(1);
    chk("R7 125 range", 32'(freq_sel), 32'h2);
    cfreq = 2'b01;
    cyc(1);
    chk("R7 50 range", 32'(freq_sel), 32'h1);
    cfreq = 2'b11;
    cyc(1);
    chk("R8 reserved", 32'({freq_rsvd, freq_sel}), 32'h4);
    fsw = 1'b0;

    power_up(2'b00);
    chk("R5 low strap", 32'(mode_rb), 0);
    power_up(2'b01);
    chk("R5 mid strap", 32'(mode_rb), 32'h1);
    power_up(2'b11);
    chk("R5 code 11 as mid", 32'(mode_rb), 32'h1);
    cyc(3);

    done = 1;
    summary();
  end

endmodule